// File: doc/BRIEF.md
# DMA Completion Action Unit

This unit carries out the bookkeeping that follows a finished DMA instruction. When the data mover reports that an instruction is complete, the unit takes a snapshot of that instruction's header fields and its byte total. The header fields are the transfer direction, the counter select, the counter-add flag, the force-interrupt flag, the work-queue flag and a 40-bit completion pointer. The unit then performs up to three actions in a fixed sequence.

The first action adds to one of two 32-bit completion counters. The second sets one of two sticky forced-interrupt bits. The third acts on the pointer. It either hands the pointer to the work scheduler as a work-queue entry, or requests a one-byte zero write at that address in local memory. In per-core mode, a small pointer instead bumps a per-core counter.

Counter and interrupt actions apply only to transfers that write into bus memory. These are outbound and bus-to-bus transfers. Pointer requests leave through valid/ready handshakes. A one-cycle `done` pulse closes each instruction.

Top module: `dma_cmpl_unit`

## Requirements
- R1: After reset, both counters, both interrupt bits and every per-core counter are zero, `cmplReady` is 1, and `wqValid`, `zwValid`, `done` and `hdrErr` are 0.
- R2: With `cntAdd`=1 and `xferType` equal to 0 (outbound) or 3 (bus-to-bus), the counter chosen by `cntSel` is updated: `cntSel`=0 selects `cnt0` and `cntSel`=1 selects `cnt1`. The other counter is left alone. Codes 1 (inbound) and 2 (local-to-local) never change a counter.
- R3: The counter increment is 1 when `incByOne` is 1, and the zero-extended `byteTotal` when `incByOne` is 0. Both `incByOne` and `perCoreMode` are captured together with the header.
- R4: With `forceIrq`=1 on transfer code 0 or 3, bit `cntSel` of `irqBits` is set. It stays set until the matching `irqClear` bit is pulsed.
- R5: A zero completion pointer produces no work-queue request, no zero-write request and no per-core count.
- R6: A nonzero pointer with `wqFlag`=1 raises `wqValid` with `wqPtr` equal to the pointer, whatever `perCoreMode` is.
- R7: A nonzero pointer with `wqFlag`=0 raises `zwValid` with `zwAddr` equal to the pointer. The one exception is the per-core case of R8.
- R8: With `perCoreMode`=1, `wqFlag`=0 and 0 < pointer < 64, per-core counter number (pointer[5:0] − 1) is incremented by 1 and no zero write is issued. If that index is at or above `NUM_CORES`, nothing happens.
- R9: Actions run in a fixed order: counter update, then interrupt, then pointer request. `done` pulses for one cycle only after the pointer request has been accepted, and a request holds `valid` and its address stable while `ready` is low.
- R10: A `cntClear` bit zeroes its counter. When a clear and an update hit the same counter in one cycle, the clear wins.
- R11: On transfer code 1 or 2, if any of `cntAdd`, `forceIrq` or `cntSel` is set, `hdrErr` pulses for one cycle. Those bits are then ignored: no counter or interrupt changes.
- R12: `cmplReady` is low from acceptance until the cycle after `done`. A completion presented in that window is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmplValid | input | 1 | Instruction complete, header fields valid |
| cmplReady | output | 1 | Unit idle, completion accepted |
| xferType | input | 2 | 0 outbound, 1 inbound, 2 local-to-local, 3 bus-to-bus |
| cntSel | input | 1 | Counter / interrupt bit select |
| cntAdd | input | 1 | Request counter update |
| forceIrq | input | 1 | Request forced interrupt |
| wqFlag | input | 1 | Pointer is a work-queue entry |
| compPtr | input | PTR_W | Completion pointer |
| byteTotal | input | BYTE_W | Bytes moved by the instruction |
| incByOne | input | 1 | Global mode: increment by one |
| perCoreMode | input | 1 | Global mode: small pointers select a per-core counter |
| cntClear | input | 2 | Write-one-to-clear strobes for the counters |
| irqClear | input | 2 | Write-one-to-clear strobes for the interrupt bits |
| cnt0 | output | CNT_W | Completion counter 0 |
| cnt1 | output | CNT_W | Completion counter 1 |
| irqBits | output | 2 | Forced-interrupt bits |
| coreCnt | output | NUM_CORES*CORE_W | Per-core counters, core 0 in the low bits |
| wqValid | output | 1 | Work-queue submission request |
| wqReady | input | 1 | Work-queue request accepted |
| wqPtr | output | PTR_W | Work-queue entry pointer |
| zwValid | output | 1 | Zero-byte write request |
| zwReady | input | 1 | Zero-byte write accepted |
| zwAddr | output | PTR_W | Byte address to zero |
| hdrErr | output | 1 | Reserved-bit violation pulse |
| done | output | 1 | All actions of the instruction finished |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a pointer request is never raised with a zero address;
- the two requests never overlap, and each holds steady under back-pressure;
- `done` never coincides with an open request or with `cmplReady`;
- interrupt bits only rise unless cleared;
- a clear strobe always zeroes its counter;
- a flagged header leaves both counters unchanged.

Other behaviours only the bench's scenarios can show. These are the decode of direction against counter select, the choice between byte total and unit increment, and the selection among work-queue, zero-write and per-core actions. They also include the per-core index arithmetic and its out-of-range drop, and a counter update being visible while the pointer request is still stalled.

// File: rtl/dma_cmpl_pkg.sv
package dma_cmpl_pkg;
  typedef enum logic [1:0] {
    XF_OUT   = 2'd0,
    XF_IN    = 2'd1,
    XF_LOCAL = 2'd2,
    XF_BUS   = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    PA_NONE = 2'd0,
    PA_WQ   = 2'd1,
    PA_ZERO = 2'd2,
    PA_CORE = 2'd3
  } ptr_act_e;

  typedef struct packed {
    logic latch;
    logic cntStep;
    logic irqStep;
    logic coreStep;
  } cmpl_strobe_t;
endpackage

// File: rtl/dma_cmpl_dp.sv
module dma_cmpl_dp
  import dma_cmpl_pkg::*;
#(
  parameter int PTR_W     = 40,
  parameter int BYTE_W    = 16,
  parameter int CNT_W     = 32,
  parameter int NUM_CORES = 8,
  parameter int CORE_W    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  cmpl_strobe_t                stb,
  input  logic [1:0]                  xferType,
  input  logic                        cntSel,
  input  logic                        cntAdd,
  input  logic                        forceIrq,
  input  logic                        wqFlag,
  input  logic [PTR_W-1:0]            compPtr,
  input  logic [BYTE_W-1:0]           byteTotal,
  input  logic                        incByOne,
  input  logic                        perCoreMode,
  input  logic [1:0]                  cntClear,
  input  logic [1:0]                  irqClear,
  output ptr_act_e                    ptrAct,
  output logic [PTR_W-1:0]            ptrQ,
  output logic [2*CNT_W-1:0]          cntFlat,
  output logic [1:0]                  irqBits,
  output logic [NUM_CORES*CORE_W-1:0] coreCnt,
  output logic                        hdrErr
);
  localparam int IDX_W = 6;

  xfer_e             typQ;
  logic              selQ, addQ, fiQ, wqQ, oneQ, coreModeQ;
  logic [BYTE_W-1:0] bytesQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typQ <= XF_OUT; selQ <= 1'b0; addQ <= 1'b0; fiQ <= 1'b0;
      wqQ <= 1'b0; oneQ <= 1'b0; coreModeQ <= 1'b0;
      ptrQ <= '0; bytesQ <= '0;
    end else if (stb.latch) begin
      typQ <= xfer_e'(xferType); selQ <= cntSel; addQ <= cntAdd;
      fiQ <= forceIrq; wqQ <= wqFlag; oneQ <= incByOne;
      coreModeQ <= perCoreMode; ptrQ <= compPtr; bytesQ <= byteTotal;
    end
  end

  logic             toBus, resvBad, doCnt, doIrq, ptrSmall;
  logic [IDX_W-1:0] coreIdx;
  logic [CNT_W-1:0] incAmt;

  always_comb begin
    toBus    = (typQ == XF_OUT) || (typQ == XF_BUS);
    resvBad  = !toBus && (addQ || fiQ || selQ);
    doCnt    = toBus && addQ;
    doIrq    = toBus && fiQ;
    ptrSmall = (ptrQ[PTR_W-1:IDX_W] == '0);
    coreIdx  = ptrQ[IDX_W-1:0] - 1'b1;
    incAmt   = oneQ ? CNT_W'(1) : CNT_W'(bytesQ);
    if (ptrQ == '0)                  ptrAct = PA_NONE;
    else if (wqQ)                    ptrAct = PA_WQ;
    else if (coreModeQ && ptrSmall)
      ptrAct = (32'(coreIdx) < 32'(NUM_CORES)) ? PA_CORE : PA_NONE;
    else                             ptrAct = PA_ZERO;
  end

  assign hdrErr = stb.cntStep && resvBad;

  for (genvar i = 0; i < 2; i++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN || cntClear[i])                          cntQ <= '0;
      else if (stb.cntStep && doCnt && (selQ == 1'(i)))  cntQ <= cntQ + incAmt;
    end
    always_ff @(posedge clk) begin
      if (!rstN || irqClear[i])                          irqBits[i] <= 1'b0;
      else if (stb.irqStep && doIrq && (selQ == 1'(i)))  irqBits[i] <= 1'b1;
    end
    assign cntFlat[i*CNT_W +: CNT_W] = cntQ;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    logic [CORE_W-1:0] coreQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                          coreQ <= '0;
      else if (stb.coreStep && (32'(coreIdx) == 32'(c)))  coreQ <= coreQ + 1'b1;
    end
    assign coreCnt[c*CORE_W +: CORE_W] = coreQ;
  end
endmodule

// File: rtl/dma_cmpl_ctrl.sv
module dma_cmpl_ctrl
  import dma_cmpl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmplValid,
  input  ptr_act_e     ptrAct,
  input  logic         wqReady,
  input  logic         zwReady,
  output logic         cmplReady,
  output cmpl_strobe_t stb,
  output logic         wqValid,
  output logic         zwValid,
  output logic         done
);
  typedef enum logic [2:0] {S_IDLE, S_CNT, S_IRQ, S_PTR, S_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext    = state;
    stb          = '0;
    wqValid      = 1'b0;
    zwValid      = 1'b0;
    cmplReady    = (state == S_IDLE);
    done         = (state == S_DONE);
    stb.latch    = (state == S_IDLE) && cmplValid;
    stb.cntStep  = (state == S_CNT);
    stb.irqStep  = (state == S_IRQ);
    case (state)
      S_IDLE: if (cmplValid) stateNext = S_CNT;
      S_CNT:  stateNext = S_IRQ;
      S_IRQ:  stateNext = S_PTR;
      S_PTR: begin
        case (ptrAct)
          PA_WQ:   begin wqValid = 1'b1; if (wqReady) stateNext = S_DONE; end
          PA_ZERO: begin zwValid = 1'b1; if (zwReady) stateNext = S_DONE; end
          PA_CORE: begin stb.coreStep = 1'b1; stateNext = S_DONE; end
          default: stateNext = S_DONE;
        endcase
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/dma_cmpl_unit.sv
module dma_cmpl_unit
  import dma_cmpl_pkg::*;
#(
  parameter int PTR_W     = 40,
  parameter int BYTE_W    = 16,
  parameter int CNT_W     = 32,
  parameter int NUM_CORES = 8,
  parameter int CORE_W    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmplValid,
  output logic                        cmplReady,
  input  logic [1:0]                  xferType,
  input  logic                        cntSel,
  input  logic                        cntAdd,
  input  logic                        forceIrq,
  input  logic                        wqFlag,
  input  logic [PTR_W-1:0]            compPtr,
  input  logic [BYTE_W-1:0]           byteTotal,
  input  logic                        incByOne,
  input  logic                        perCoreMode,
  input  logic [1:0]                  cntClear,
  input  logic [1:0]                  irqClear,
  output logic [CNT_W-1:0]            cnt0,
  output logic [CNT_W-1:0]            cnt1,
  output logic [1:0]                  irqBits,
  output logic [NUM_CORES*CORE_W-1:0] coreCnt,
  output logic                        wqValid,
  input  logic                        wqReady,
  output logic [PTR_W-1:0]            wqPtr,
  output logic                        zwValid,
  input  logic                        zwReady,
  output logic [PTR_W-1:0]            zwAddr,
  output logic                        hdrErr,
  output logic                        done
);
  cmpl_strobe_t       stb;
  ptr_act_e           ptrAct;
  logic [PTR_W-1:0]   ptrQ;
  logic [2*CNT_W-1:0] cntFlat;

  dma_cmpl_ctrl u_ctrl (
    .clk, .rstN, .cmplValid, .ptrAct, .wqReady, .zwReady,
    .cmplReady, .stb, .wqValid, .zwValid, .done
  );

  dma_cmpl_dp #(
    .PTR_W(PTR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)
  ) u_dp (
    .clk, .rstN, .stb, .xferType, .cntSel, .cntAdd, .forceIrq, .wqFlag,
    .compPtr, .byteTotal, .incByOne, .perCoreMode, .cntClear, .irqClear,
    .ptrAct, .ptrQ, .cntFlat, .irqBits, .coreCnt, .hdrErr
  );

  assign cnt0   = cntFlat[CNT_W-1:0];
  assign cnt1   = cntFlat[2*CNT_W-1:CNT_W];
  assign wqPtr  = ptrQ;
  assign zwAddr = ptrQ;
endmodule

// File: rtl/dma_cmpl_unit_chk.sv
module dma_cmpl_unit_chk #(
  parameter int PTR_W = 40,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmplReady,
  input logic             wqValid,
  input logic             wqReady,
  input logic [PTR_W-1:0] wqPtr,
  input logic             zwValid,
  input logic             zwReady,
  input logic [PTR_W-1:0] zwAddr,
  input logic             done,
  input logic             hdrErr,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [1:0]       cntClear,
  input logic [1:0]       irqBits,
  input logic [1:0]       irqClear
);
  a_r5_wq_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    wqValid |-> (wqPtr != '0));
  a_r5_zw_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    zwValid |-> (zwAddr != '0));
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(wqValid && zwValid));
  a_r9_wq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wqValid && !wqReady) |=> (wqValid && $stable(wqPtr)));
  a_r9_zw_hold: assert property (@(posedge clk) disable iff (!rstN)
    (zwValid && !zwReady) |=> (zwValid && $stable(zwAddr)));
  a_r9_done_closed: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!wqValid && !zwValid));
  a_r12_busy_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmplReady);
  a_r10_clear0: assert property (@(posedge clk) disable iff (!rstN)
    cntClear[0] |=> (cnt0 == '0));
  a_r10_clear1: assert property (@(posedge clk) disable iff (!rstN)
    cntClear[1] |=> (cnt1 == '0));
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear == 2'b00) |=> ((irqBits & $past(irqBits)) == $past(irqBits)));
  a_r11_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (hdrErr && cntClear == 2'b00) |=> ($stable(cnt0) && $stable(cnt1)));
endmodule

bind dma_cmpl_unit dma_cmpl_unit_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_dma_cmpl_unit.sv
module tb_dma_cmpl_unit;
  localparam int NC = 8;
  localparam logic [6:0] NOC = 7'h7f;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic cmplValid = 0, cmplReady, cntSel = 0, cntAdd = 0, forceIrq = 0, wqFlag = 0;
  logic [1:0] xferType = 0, cntClear = 0, irqClear = 0, irqBits;
  logic [39:0] compPtr = 0, wqPtr, zwAddr;
  logic [15:0] byteTotal = 0;
  logic incByOne = 0, perCoreMode = 0;
  logic [31:0] cnt0, cnt1;
  logic [NC*16-1:0] coreCnt;
  logic wqValid, wqReady = 1, zwValid, zwReady = 1, hdrErr, done;

  dma_cmpl_unit dut (.*);

  int checks = 0, errors = 0;
  int wqSeen = 0, zwSeen = 0, errSeen = 0;
  logic [39:0] lastWq = 0, lastZw = 0;
  int expCore [NC];

  always @(posedge clk) begin
    if (wqValid && wqReady) begin wqSeen++; lastWq <= wqPtr; end
    if (zwValid && zwReady) begin zwSeen++; lastZw <= zwAddr; end
    if (hdrErr) errSeen++;
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] typ; logic sel, add, fi, wq; logic [39:0] ptr; logic [15:0] bytes;
    logic one, core; logic [31:0] e0, e1; logic [1:0] eIrq; logic eWq, eZw, eErr;
    logic [6:0] eCore;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b1,1'b0,1'b0,40'h0,   16'd100,  1'b0,1'b0,32'd100,  32'd0,    2'b00,1'b0,1'b0,1'b0,NOC},
    '{2'd0,1'b1,1'b1,1'b1,1'b1,40'h1000,16'd50,   1'b1,1'b0,32'd0,    32'd1,    2'b10,1'b1,1'b0,1'b0,NOC},
    '{2'd3,1'b0,1'b1,1'b1,1'b0,40'h2345,16'd7,    1'b0,1'b0,32'd7,    32'd0,    2'b01,1'b0,1'b1,1'b0,NOC},
    '{2'd1,1'b0,1'b0,1'b0,1'b1,40'h88,  16'd9,    1'b0,1'b0,32'd0,    32'd0,    2'b00,1'b1,1'b0,1'b0,NOC},
    '{2'd2,1'b0,1'b1,1'b0,1'b0,40'h0,   16'd9,    1'b0,1'b0,32'd0,    32'd0,    2'b00,1'b0,1'b0,1'b1,NOC},
    '{2'd1,1'b1,1'b0,1'b1,1'b0,40'h40,  16'd3,    1'b0,1'b1,32'd0,    32'd0,    2'b00,1'b0,1'b1,1'b1,NOC},
    '{2'd0,1'b0,1'b0,1'b1,1'b0,40'h0,   16'd5,    1'b0,1'b0,32'd0,    32'd0,    2'b01,1'b0,1'b0,1'b0,NOC},
    '{2'd0,1'b0,1'b1,1'b0,1'b0,40'h3,   16'd20,   1'b0,1'b1,32'd20,   32'd0,    2'b00,1'b0,1'b0,1'b0,7'd2},
    '{2'd2,1'b0,1'b0,1'b0,1'b0,40'h1,   16'd4,    1'b0,1'b1,32'd0,    32'd0,    2'b00,1'b0,1'b0,1'b0,7'd0},
    '{2'd2,1'b0,1'b0,1'b0,1'b0,40'h3f,  16'd4,    1'b0,1'b1,32'd0,    32'd0,    2'b00,1'b0,1'b0,1'b0,NOC},
    '{2'd2,1'b0,1'b0,1'b0,1'b0,40'h40,  16'd4,    1'b0,1'b1,32'd0,    32'd0,    2'b00,1'b0,1'b1,1'b0,NOC},
    '{2'd2,1'b0,1'b0,1'b0,1'b1,40'h8,   16'd4,    1'b0,1'b1,32'd0,    32'd0,    2'b00,1'b1,1'b0,1'b0,NOC},
    '{2'd3,1'b0,1'b0,1'b0,1'b0,40'h0,   16'd4,    1'b0,1'b1,32'd0,    32'd0,    2'b00,1'b0,1'b0,1'b0,NOC},
    '{2'd3,1'b1,1'b1,1'b0,1'b0,40'h0,   16'hffff, 1'b0,1'b0,32'd0,    32'd65535,2'b00,1'b0,1'b0,1'b0,NOC}
  };

  task automatic clearAll();
    @(negedge clk); cntClear = 2'b11; irqClear = 2'b11;
    @(negedge clk); cntClear = 2'b00; irqClear = 2'b00;
  endtask

  task automatic issue(vec_t v);
    @(negedge clk);
    xferType = v.typ; cntSel = v.sel; cntAdd = v.add; forceIrq = v.fi; wqFlag = v.wq;
    compPtr = v.ptr; byteTotal = v.bytes; incByOne = v.one; perCoreMode = v.core;
    cmplValid = 1'b1;
    @(negedge clk); cmplValid = 1'b0;
  endtask

  task automatic waitDone();
    for (int k = 0; k < 50 && !done; k++) @(negedge clk);
    chk("R9 done reached", done, 1);
  endtask

  task automatic checkCores(string req);
    for (int c = 0; c < NC; c++) chk(req, coreCnt[c*16 +: 16], expCore[c]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) expCore[c] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnt0", cnt0, 0); chk("R1 cnt1", cnt1, 0); chk("R1 irq", irqBits, 0);
    chk("R1 ready", cmplReady, 1); chk("R1 valids", {wqValid, zwValid, done, hdrErr}, 0);
    checkCores("R1 core");
    rstN = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      int w0, z0, e0;
      clearAll();
      w0 = wqSeen; z0 = zwSeen; e0 = errSeen;
      issue(VECS[i]);
      waitDone();
      if (VECS[i].eCore != NOC) expCore[VECS[i].eCore] = expCore[VECS[i].eCore] + 1;
      chk("R2 R3 cnt0", cnt0, VECS[i].e0);
      chk("R2 R3 cnt1", cnt1, VECS[i].e1);
      chk("R4 irqBits", irqBits, VECS[i].eIrq);
      chk("R5 R6 wq count", wqSeen - w0, VECS[i].eWq);
      chk("R5 R7 zw count", zwSeen - z0, VECS[i].eZw);
      if (VECS[i].eWq) chk("R6 wqPtr", lastWq, VECS[i].ptr);
      if (VECS[i].eZw) chk("R7 zwAddr", lastZw, VECS[i].ptr);
      chk("R11 hdrErr", errSeen - e0, VECS[i].eErr);
      checkCores("R8 core counters");
    end

    // R4 stickiness across a later instruction
    clearAll();
    issue('{2'd0,1'b1,1'b0,1'b1,1'b0,40'h0,16'd1,1'b0,1'b0,32'd0,32'd0,2'b10,1'b0,1'b0,1'b0,NOC});
    waitDone();
    issue('{2'd0,1'b0,1'b0,1'b0,1'b0,40'h0,16'd1,1'b0,1'b0,32'd0,32'd0,2'b00,1'b0,1'b0,1'b0,NOC});
    waitDone();
    chk("R4 sticky irq", irqBits, 2'b10);

    // R10 clear beats a same-cycle update
    clearAll();
    issue('{2'd0,1'b0,1'b1,1'b0,1'b0,40'h0,16'd30,1'b0,1'b0,32'd0,32'd0,2'b00,1'b0,1'b0,1'b0,NOC});
    waitDone();
    chk("R10 prior value", cnt0, 30);
    @(negedge clk);
    xferType = 2'd0; cntSel = 1'b0; cntAdd = 1'b1; forceIrq = 1'b0; wqFlag = 1'b0;
    compPtr = '0; byteTotal = 16'd5; incByOne = 1'b0; cmplValid = 1'b1;
    @(negedge clk); cmplValid = 1'b0; cntClear = 2'b01;   // update edge ends this cycle
    @(negedge clk); cntClear = 2'b00;
    waitDone();
    chk("R10 clear wins", cnt0, 0);

    // R9 / R12 back-pressure on the zero write
    clearAll();
    zwReady = 1'b0;
    issue('{2'd0,1'b0,1'b1,1'b0,1'b0,40'h777,16'd11,1'b0,1'b0,32'd0,32'd0,2'b00,1'b0,1'b0,1'b0,NOC});
    @(negedge clk); cmplValid = 1'b1; xferType = 2'd0; cntAdd = 1'b1; byteTotal = 16'd99;
    repeat (8) @(negedge clk);
    cmplValid = 1'b0;
    chk("R9 stalled zwValid", zwValid, 1);
    chk("R9 no early done", done, 0);
    chk("R9 counter before pointer", cnt0, 11);
    chk("R12 busy not ready", cmplReady, 0);
    zwReady = 1'b1;
    waitDone();
    chk("R9 zwAddr", lastZw, 40'h777);
    @(negedge clk);
    chk("R12 ready after done", cmplReady, 1);
    chk("R12 busy completion dropped", cnt0, 11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule